// File: doc/BRIEF.md
# Programmable SDA Output Delay Unit

This block sits between the shift register of an I2C-capable serial port and the SDA pad driver. It holds back the serial data output for a chosen number of core clock cycles. Two small configuration registers control it. The control register holds a select bit that turns on the digital delay path. The delay register holds a 3-bit delay code and two serial-mode bits, a SPI-mode bit and a clock-phase bit, that share its address.

When the delay code is zero, the data takes the bypass path, which stands for the external analog delay. When the code is nonzero, the data runs through a line of flip-flops, and the output is taken from the stage that matches the code. The delay register only accepts writes while the select bit is set. Clearing the select bit returns the delay code to bypass at once.

Top module: `sda_delay_unit`

## Requirements
- R1: After a synchronous reset, the select bit, the delay code, the SPI-mode bit and the clock-phase bit are all 0. Both registers read 0, and `sda_out` follows `sda_raw`.
- R2: While the delay code is 000, `sda_out` equals `sda_raw` in the same cycle, with no register in the path.
- R3: A delay code n in 1..7 makes `sda_out` reproduce `sda_raw` n+1 core clock cycles later. A value set just after clock edge c appears just after edge c+n+1.
- R4: A write to the delay register (address 1) while the select bit is 0 changes no stored bit.
- R5: Writing 0 to the select bit forces the delay code to 000 on the same edge. From the next cycle the output is on the bypass path. The SPI-mode and clock-phase bits keep their values.
- R6: While the select bit is 0, a read of the delay register returns 0.
- R7: The register map is as follows. The control register is at address 0, with the select bit at bit 0. The delay register is at address 1, with the code at bits [2:0], the SPI-mode bit at bit 3 and the clock-phase bit at bit 4. All other bits of either register read 0.
- R8: A new delay code takes effect on the clock edge that writes it. Output data is taken from the new tap starting in the cycle right after that edge.
- R9: While the select bit is 1, the delay code, SPI-mode and clock-phase bits can be written and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register address (0 control, 1 delay) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| sda_raw | input | 1 | Serial data from the port shifter |
| sda_out | output | 1 | Serial data toward the SDA pad |

## Verification
The hardest case to reach is a code change while data is in flight. It needs the delay line filled with a known history that differs between the old tap and the new one. The bench first holds `sda_raw` high at the longest delay, then drives three low cycles. It then writes a short code and samples on both sides of the write edge, where the output must flip from 1 to 0. A second hard case is the sequence that shows the mode bits surviving a select clear while the code does not: write all ones, clear select, set select again, and read back.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    // Depth of the digital delay line and the width of the code that picks a tap
    localparam int DLY_DEPTH  = 8;
    localparam int DLY_CODE_W = $clog2(DLY_DEPTH);

    // Register addresses and field positions
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DLY  = 1'b1;
    localparam int   SEL_BIT   = 0;
    localparam int   SPI_BIT   = DLY_CODE_W;
    localparam int   PHA_BIT   = DLY_CODE_W + 1;
    localparam int   DLY_REG_W = DLY_CODE_W + 2;

    typedef struct packed {
        logic                  phase;
        logic                  spi;
        logic [DLY_CODE_W-1:0] code;
    } dly_reg_t;

    typedef enum logic {
        PATH_BYPASS  = 1'b0,
        PATH_DIGITAL = 1'b1
    } path_e;

    function automatic path_e path_of(input logic [DLY_CODE_W-1:0] code);
        return (code == '0) ? PATH_BYPASS : PATH_DIGITAL;
    endfunction

endpackage

// File: rtl/sdd_regs.sv
module sdd_regs
    import sdd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sel_o,
    output dly_reg_t          cfg_o
);

    logic     sel_q;
    dly_reg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            cfg_q <= '0;
        end else if (we) begin
            if (addr == ADDR_CTRL) begin
                sel_q <= wdata[SEL_BIT];
                if (!wdata[SEL_BIT])
                    cfg_q.code <= '0;
            end else if (sel_q) begin
                cfg_q <= dly_reg_t'(wdata[DLY_REG_W-1:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL)
            rdata[SEL_BIT] = sel_q;
        else if (sel_q)
            rdata[DLY_REG_W-1:0] = cfg_q;
    end

    logic wdata_unused;
    assign wdata_unused = ^wdata[DATA_W-1:DLY_REG_W];

    assign sel_o = sel_q;
    assign cfg_o = cfg_q;

    // R5: the code is at bypass whenever the select bit is clear
    p_code_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        !sel_q |-> cfg_q.code == '0);

    // R4: a delay-register write with select clear leaves every field alone
    p_locked_write_r4: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_DLY && !sel_q) |=> $stable(cfg_q));

    // R6: a delay-register read with select clear gives zero
    p_locked_read_r6: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_DLY && !sel_q) |-> rdata == '0);

    // R7: bits outside the defined fields read zero
    p_unassigned_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:DLY_REG_W] == '0);

endmodule

// File: rtl/sdd_shift_line.sv
module sdd_shift_line
    import sdd_pkg::*;
#(
    parameter int DEPTH = DLY_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);

    logic [DEPTH-1:0] stage_q;

    genvar j;
    generate
        for (j = 0; j < DEPTH; j++) begin : g_stage
            if (j == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= din;
                end
                // R3: the first stage holds the input seen at the last edge
                p_head_capture_r3: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> stage_q[0] == $past(din));
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage_q[j] <= 1'b0;
                    else     stage_q[j] <= stage_q[j-1];
                end
                // R3: each later stage trails its neighbour by one cycle
                p_stage_shift_r3: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> stage_q[j] == $past(stage_q[j-1]));
            end
        end
    endgenerate

    assign taps = stage_q;

endmodule

// File: rtl/sdd_tap_mux.sv
module sdd_tap_mux
    import sdd_pkg::*;
#(
    parameter int DEPTH = DLY_DEPTH
) (
    input  logic                  raw,
    input  logic [DEPTH-1:0]      taps,
    input  logic [DLY_CODE_W-1:0] code,
    output logic                  dout
);

    path_e path;

    always_comb begin
        path = path_of(code);
        dout = raw;
        if (path == PATH_DIGITAL)
            dout = taps[code];
    end

endmodule

// File: rtl/sda_delay_unit.sv
module sda_delay_unit
    import sdd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              sda_raw,
    output logic              sda_out
);

    logic                 sel;
    dly_reg_t             cfg;
    logic [DLY_DEPTH-1:0] taps;

    sdd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .sel_o (sel),
        .cfg_o (cfg)
    );

    sdd_shift_line #(.DEPTH(DLY_DEPTH)) u_line (
        .clk  (clk),
        .rst  (rst),
        .din  (sda_raw),
        .taps (taps)
    );

    sdd_tap_mux #(.DEPTH(DLY_DEPTH)) u_mux (
        .raw  (sda_raw),
        .taps (taps),
        .code (cfg.code),
        .dout (sda_out)
    );

    logic sel_unused;
    assign sel_unused = sel;

    // R2: with a zero code the pad sees the shifter output directly
    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        cfg.code == '0 |-> sda_out == sda_raw);

    // R1: reset leaves the register file cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (cfg == '0 && !sel));

endmodule

// File: tb/tb_sda_delay_unit.sv
`timescale 1ns/1ps
module tb_sda_delay_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       sda_raw = 1'b0;
    logic       sda_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic  val;
        int    due;
        string req;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sda_delay_unit dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sda_raw(sda_raw), .sda_out(sda_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare queued expectations at the falling edge of their cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, {7'd0, sda_out}, {7'd0, it.val});
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic a, input logic [7:0] exp);
        cfg_addr = a; #0.5;
        check(req, cfg_rdata, exp);
    endtask

    // driver: each bit is pushed with the cycle in which it must appear
    task automatic stream(input int code, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            item_t it;
            sda_raw = 1'($urandom);
            it.val = sda_raw;
            it.due = (code == 0) ? cyc : cyc + code + 1;
            it.req = req;
            sb_q.push_back(it);
            @(posedge clk); #1;
        end
        while (sb_q.size() > 0) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd_check("R1 ctrl", 1'b0, 8'h00);
        rd_check("R1 dly", 1'b1, 8'h00);
        sda_raw = 1'b1; #0.5;
        check("R1 out follows raw", {7'd0, sda_out}, 8'h01);
        sda_raw = 1'b0; #0.5;
        check("R2 out follows raw", {7'd0, sda_out}, 8'h00);

        // R4, R6: delay register locked while select clear
        wr(1'b1, 8'h1F);
        rd_check("R6 locked read", 1'b1, 8'h00);
        wr(1'b0, 8'hFF);
        rd_check("R7 ctrl unassigned", 1'b0, 8'h01);
        rd_check("R4 write ignored", 1'b1, 8'h00);

        // R9, R7: writable and masked while select set
        wr(1'b1, 8'hFF);
        rd_check("R9 readback", 1'b1, 8'h1F);
        wr(1'b1, 8'hEA);
        rd_check("R7 dly unassigned", 1'b1, 8'h0A);
        wr(1'b1, 8'h1F);

        // R5: clearing select forces bypass, keeps mode bits
        wr(1'b0, 8'h00);
        rd_check("R6 read zero", 1'b1, 8'h00);
        sda_raw = ~sda_out; #0.5;
        check("R5 bypass after clear", {7'd0, sda_out}, {7'd0, sda_raw});
        wr(1'b0, 8'h01);
        rd_check("R5 code cleared mode kept", 1'b1, 8'h18);

        // R2, R3: streams at every code
        wr(1'b1, 8'h00);
        stream(0, 24, "R2 bypass stream");
        for (int c = 1; c < 8; c++) begin
            wr(1'b1, 8'(c));
            stream(c, 24, "R3 delayed stream");
        end

        // R8: code change mid-flight
        wr(1'b1, 8'h07);
        sda_raw = 1'b1;
        repeat (10) begin @(posedge clk); #1; end
        sda_raw = 1'b0;
        repeat (3) begin @(posedge clk); #1; end
        @(negedge clk);
        check("R8 before change", {7'd0, sda_out}, 8'h01);
        #1;
        wr(1'b1, 8'h01);
        @(negedge clk);
        check("R8 after change", {7'd0, sda_out}, 8'h00);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule